// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a small single-port RAM of one-bit cells that can be made to misbehave on purpose. A configuration port picks one functional fault model, a victim cell, an aggressor cell and the fault values. From then on every access follows that model. The block gives a march-test engine a target with a known defect, so the engine's pass/fail verdict can be checked against a fault that was planted deliberately.

Each access uses one enable and one write select on a shared address. Writes change the stored array at the clock edge. A read presents its data and a valid flag on the edge that follows the request. Some faults act on what is written: a blocked transition, a lost write, or a write that lands in two cells. Others only change what a read returns: stuck cells, coupling and bridges.

Top module: `fault_ram`

## Requirements
- R1: While reset is asserted and after it is released, every cell holds 0, the fault kind is fault-free (0) and `memRvalid` is 0.
- R2: A request with `memEn`=1 and `memWe`=0 drives `memRvalid`=1 and `memRdata` on the following clock edge, for one cycle. A request with `memEn`=1 and `memWe`=1 stores `memWdata` at the addressed cell. With kind 0 the RAM is fault-free.
- R3: The fault settings are captured from the configuration inputs only on a cycle with `cfgLoad`=1, and they hold otherwise. The `cfgKind` codes are: 0 none, 1 stuck-at, 2 transition, 3 state coupling, 4 AND bridge, 5 OR bridge, 6 decoder no-access, 7 decoder multi-access.
- R4: Kind 1: a read of the victim returns `cfgValue` whatever was written to it. Other cells are unaffected.
- R5: Kind 2: a write of `cfgValue` to the victim is discarded when the victim holds the opposite value. A write in the other direction takes effect.
- R6: Kind 3: while the aggressor holds `cfgTrigger`, a read of the victim returns `cfgValue`. Otherwise the victim reads its stored bit.
- R7: Kind 4: a read of either the victim or the aggressor returns the AND of the two stored bits.
- R8: Kind 5: a read of either the victim or the aggressor returns the OR of the two stored bits.
- R9: Kind 6: a write to the victim address changes no cell, and a read of it returns 0. Other addresses behave normally.
- R10: Kind 7: a write to the victim address stores the data in both the victim and the aggressor. A read of the victim address returns the AND of the two bits. An access to the aggressor address is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Captures the fault settings |
| cfgKind | input | 3 | Fault kind code |
| cfgVictim | input | AW | Victim cell address |
| cfgAggressor | input | AW | Aggressor cell address |
| cfgValue | input | 1 | Forced, stuck or blocked value |
| cfgTrigger | input | 1 | Aggressor state that activates coupling |
| memEn | input | 1 | Access request |
| memWe | input | 1 | 1 = write, 0 = read |
| memAddr | input | AW | Access address |
| memWdata | input | 1 | Write data |
| memRdata | output | 1 | Read data, registered |
| memRvalid | output | 1 | Read data valid |

## Verification
Read data and the valid flag arrive one edge after the request. A write is visible to a read that is requested on the next cycle. A configuration load takes effect for accesses in the cycle after the load. The bench drives every input on the falling edge. It samples `memRdata` and `memRvalid` on the next falling edge, half a period after the edge that registered them. It applies each new fault setting one full cycle before the first access that depends on it.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

  typedef enum logic [2:0] {
    FK_NONE      = 3'd0,
    FK_STUCK     = 3'd1,
    FK_TRANS     = 3'd2,
    FK_COUPLE    = 3'd3,
    FK_BR_AND    = 3'd4,
    FK_BR_OR     = 3'd5,
    FK_DEC_NONE  = 3'd6,
    FK_DEC_MULTI = 3'd7
  } faultKind_e;

  typedef struct packed {
    faultKind_e kind;
    logic       value;
    logic       trigger;
  } faultCfg_t;

  // per-access strobes from control to datapath
  typedef struct packed {
    logic wrCell;   // write the addressed cell
    logic wrAlias;  // also write the aggressor cell
    logic rdCell;   // a read is requested
    logic rdZero;   // read returns constant 0
    logic rdAlias;  // read returns victim AND aggressor
  } ramStrobe_t;

endpackage

// File: rtl/fault_ram_ctrl.sv
module fault_ram_ctrl
  import fault_ram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [2:0]    cfgKind,
  input  logic [AW-1:0] cfgVictim,
  input  logic [AW-1:0] cfgAggressor,
  input  logic          cfgValue,
  input  logic          cfgTrigger,
  input  logic          memEn,
  input  logic          memWe,
  input  logic [AW-1:0] memAddr,
  output faultCfg_t     cfgQ,
  output logic [AW-1:0] victimQ,
  output logic [AW-1:0] aggressorQ,
  output ramStrobe_t    stb
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ       <= '{kind: FK_NONE, value: 1'b0, trigger: 1'b0};
      victimQ    <= '0;
      aggressorQ <= '0;
    end else if (cfgLoad) begin
      cfgQ       <= '{kind: faultKind_e'(cfgKind), value: cfgValue, trigger: cfgTrigger};
      victimQ    <= cfgVictim;
      aggressorQ <= cfgAggressor;
    end
  end

  logic wrReq, rdReq, hitVictim;
  assign wrReq     = memEn && memWe;
  assign rdReq     = memEn && !memWe;
  assign hitVictim = (memAddr == victimQ);

  always_comb begin
    stb         = '0;
    stb.rdCell  = rdReq;
    stb.wrCell  = wrReq && !(cfgQ.kind == FK_DEC_NONE && hitVictim);
    stb.wrAlias = wrReq && cfgQ.kind == FK_DEC_MULTI && hitVictim;
    stb.rdZero  = rdReq && cfgQ.kind == FK_DEC_NONE && hitVictim;
    stb.rdAlias = rdReq && cfgQ.kind == FK_DEC_MULTI && hitVictim;
  end

  // R3: settings move only on a load cycle
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> ($stable(cfgQ) && $stable(victimQ) && $stable(aggressorQ)));

  // R9 / R10: the decoder strobes never fire together
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdZero, stb.rdAlias, stb.wrAlias}));

endmodule

// File: rtl/fault_ram_dp.sv
module fault_ram_dp
  import fault_ram_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  faultCfg_t     cfgQ,
  input  logic [AW-1:0] victimQ,
  input  logic [AW-1:0] aggressorQ,
  input  ramStrobe_t    stb,
  input  logic [AW-1:0] memAddr,
  input  logic          memWdata,
  output logic          memRdata,
  output logic          memRvalid
);

  logic [DEPTH-1:0] cells;
  logic vicBit, aggBit, hitVic, hitAgg, blocked, view;

  assign vicBit = cells[victimQ];
  assign aggBit = cells[aggressorQ];
  assign hitVic = (memAddr == victimQ);
  assign hitAgg = (memAddr == aggressorQ);

  // transition fault: the victim cannot move into cfgQ.value
  assign blocked = cfgQ.kind == FK_TRANS && hitVic &&
                   memWdata == cfgQ.value && vicBit != cfgQ.value;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cells <= '0;
    end else begin
      if (stb.wrCell && !blocked) cells[memAddr] <= memWdata;
      if (stb.wrAlias) cells[aggressorQ] <= memWdata;
    end
  end

  // read-path faults
  always_comb begin
    view = cells[memAddr];
    case (cfgQ.kind)
      FK_STUCK:  if (hitVic) view = cfgQ.value;
      FK_COUPLE: if (hitVic && aggBit == cfgQ.trigger) view = cfgQ.value;
      FK_BR_AND: if (hitVic || hitAgg) view = vicBit & aggBit;
      FK_BR_OR:  if (hitVic || hitAgg) view = vicBit | aggBit;
      default:   ;
    endcase
    if (stb.rdZero) view = 1'b0;
    else if (stb.rdAlias) view = vicBit & aggBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memRdata  <= 1'b0;
      memRvalid <= 1'b0;
    end else begin
      memRvalid <= stb.rdCell;
      if (stb.rdCell) memRdata <= view;
    end
  end

  // R5: a blocked transition leaves the victim unchanged
  a_r5_trans_block: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCell && cfgQ.kind == FK_TRANS && hitVic && memWdata == cfgQ.value &&
     vicBit != cfgQ.value) |=> (cells[victimQ] == $past(vicBit)));

  // R10: a multi-access write lands in the aggressor too
  a_r10_multi_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAlias |=> (cells[$past(aggressorQ)] == $past(memWdata)));

  // R9: a lost write leaves the victim unchanged
  a_r9_lost_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.kind == FK_DEC_NONE && hitVic && !stb.wrCell && !stb.rdCell &&
     !stb.wrAlias) |=> $stable(cells[victimQ]));

endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fault_ram_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [2:0]    cfgKind,
  input  logic [AW-1:0] cfgVictim,
  input  logic [AW-1:0] cfgAggressor,
  input  logic          cfgValue,
  input  logic          cfgTrigger,
  input  logic          memEn,
  input  logic          memWe,
  input  logic [AW-1:0] memAddr,
  input  logic          memWdata,
  output logic          memRdata,
  output logic          memRvalid
);

  faultCfg_t     cfgQ;
  logic [AW-1:0] victimQ, aggressorQ;
  ramStrobe_t    stb;

  fault_ram_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgKind(cfgKind),
    .cfgVictim(cfgVictim), .cfgAggressor(cfgAggressor), .cfgValue(cfgValue),
    .cfgTrigger(cfgTrigger), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .cfgQ(cfgQ), .victimQ(victimQ), .aggressorQ(aggressorQ), .stb(stb)
  );

  fault_ram_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .victimQ(victimQ),
    .aggressorQ(aggressorQ), .stb(stb), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memRvalid(memRvalid)
  );

  // R2: every read request yields a valid pulse one edge later
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> memRvalid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && !memWe) |=> !memRvalid);

  // R4: stuck victim reads its stuck value
  a_r4_stuck_read: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe && cfgQ.kind == FK_STUCK && memAddr == victimQ)
      |=> (memRdata == $past(cfgQ.value)));

  // R9: unreachable address reads 0
  a_r9_noacc_read: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe && cfgQ.kind == FK_DEC_NONE && memAddr == victimQ)
      |=> !memRdata);

endmodule

// File: tb/tb_fault_ram.sv
module tb_fault_ram;

  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [2:0] cfgKind = '0;
  logic [AW-1:0] cfgVictim = '0, cfgAggressor = '0;
  logic cfgValue = 1'b0, cfgTrigger = 1'b0;
  logic memEn = 1'b0, memWe = 1'b0, memWdata = 1'b0;
  logic [AW-1:0] memAddr = '0;
  logic memRdata, memRvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_ram #(.DEPTH(16)) dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgKind(cfgKind),
    .cfgVictim(cfgVictim), .cfgAggressor(cfgAggressor), .cfgValue(cfgValue),
    .cfgTrigger(cfgTrigger), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memRvalid(memRvalid)
  );

  typedef struct packed {
    logic [2:0] kind;
    logic [3:0] vic;
    logic [3:0] agg;
    logic       val;
    logic       trg;
    logic       we;
    logic [3:0] addr;
    logic       wd;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 49;
  // kind vic agg val trg | we addr wd exp | req
  localparam vec_t VEC [NV] = '{
    // R2 fault-free
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b1,4'd3,1'b1,1'b0, 4'd2},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b0,4'd3,1'b0,1'b1, 4'd2},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b0,4'd4,1'b0,1'b0, 4'd2},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b1,4'd3,1'b0,1'b0, 4'd2},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b0,4'd3,1'b0,1'b0, 4'd2},
    // R4 stuck-at-1 on cell 5
    '{3'd1,4'd5,4'd0,1'b1,1'b0, 1'b0,4'd5,1'b0,1'b1, 4'd4},
    '{3'd1,4'd5,4'd0,1'b1,1'b0, 1'b1,4'd5,1'b0,1'b0, 4'd4},
    '{3'd1,4'd5,4'd0,1'b1,1'b0, 1'b0,4'd5,1'b0,1'b1, 4'd4},
    '{3'd1,4'd5,4'd0,1'b1,1'b0, 1'b0,4'd6,1'b0,1'b0, 4'd4},
    // R4 stuck-at-0 on cell 5 (stored becomes 1)
    '{3'd1,4'd5,4'd0,1'b0,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd4},
    '{3'd1,4'd5,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd4},
    // R5 cell 5 cannot rise
    '{3'd2,4'd5,4'd0,1'b1,1'b0, 1'b1,4'd5,1'b0,1'b0, 4'd5},
    '{3'd2,4'd5,4'd0,1'b1,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd5},
    '{3'd2,4'd5,4'd0,1'b1,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd5},
    '{3'd2,4'd5,4'd0,1'b1,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd5},
    '{3'd2,4'd5,4'd0,1'b1,1'b0, 1'b1,4'd6,1'b1,1'b0, 4'd5},
    '{3'd2,4'd5,4'd0,1'b1,1'b0, 1'b0,4'd6,1'b0,1'b1, 4'd5},
    // R5 cell 5 cannot fall
    '{3'd2,4'd5,4'd0,1'b0,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd5},
    '{3'd2,4'd5,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b1, 4'd5},
    '{3'd2,4'd5,4'd0,1'b0,1'b0, 1'b1,4'd5,1'b0,1'b0, 4'd5},
    '{3'd2,4'd5,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b1, 4'd5},
    // R6 coupling: cell 9 at 1 forces cell 5 to 0
    '{3'd3,4'd5,4'd9,1'b0,1'b1, 1'b0,4'd5,1'b0,1'b1, 4'd6},
    '{3'd3,4'd5,4'd9,1'b0,1'b1, 1'b1,4'd9,1'b1,1'b0, 4'd6},
    '{3'd3,4'd5,4'd9,1'b0,1'b1, 1'b0,4'd5,1'b0,1'b0, 4'd6},
    '{3'd3,4'd5,4'd9,1'b0,1'b1, 1'b0,4'd9,1'b0,1'b1, 4'd6},
    '{3'd3,4'd5,4'd9,1'b0,1'b1, 1'b1,4'd9,1'b0,1'b0, 4'd6},
    '{3'd3,4'd5,4'd9,1'b0,1'b1, 1'b0,4'd5,1'b0,1'b1, 4'd6},
    // R7 AND bridge 5/9 (5=1, 9=0)
    '{3'd4,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd7},
    '{3'd4,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd9,1'b0,1'b0, 4'd7},
    '{3'd4,4'd5,4'd9,1'b0,1'b0, 1'b1,4'd9,1'b1,1'b0, 4'd7},
    '{3'd4,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b1, 4'd7},
    '{3'd4,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd9,1'b0,1'b1, 4'd7},
    // R8 OR bridge 5/9
    '{3'd5,4'd5,4'd9,1'b0,1'b0, 1'b1,4'd5,1'b0,1'b0, 4'd8},
    '{3'd5,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b1, 4'd8},
    '{3'd5,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd9,1'b0,1'b1, 4'd8},
    '{3'd5,4'd5,4'd9,1'b0,1'b0, 1'b1,4'd9,1'b0,1'b0, 4'd8},
    '{3'd5,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd8},
    '{3'd5,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd9,1'b0,1'b0, 4'd8},
    // R9 address 5 reaches nothing
    '{3'd6,4'd5,4'd0,1'b0,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd9},
    '{3'd6,4'd5,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd9},
    '{3'd6,4'd5,4'd0,1'b0,1'b0, 1'b0,4'd6,1'b0,1'b1, 4'd9},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd9},
    // R10 address 5 reaches cells 5 and 9
    '{3'd7,4'd5,4'd9,1'b0,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd10},
    '{3'd7,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd9,1'b0,1'b1, 4'd10},
    '{3'd7,4'd5,4'd9,1'b0,1'b0, 1'b1,4'd9,1'b0,1'b0, 4'd10},
    '{3'd7,4'd5,4'd9,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0, 4'd10},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b1, 4'd10},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b0,4'd9,1'b0,1'b0, 4'd10},
    '{3'd0,4'd0,4'd0,1'b0,1'b0, 1'b0,4'd6,1'b0,1'b1, 4'd2}
  };

  task automatic check(input int req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic loadCfg(input logic [2:0] k, input logic [3:0] v, input logic [3:0] a,
                         input logic val, input logic trg);
    @(negedge clk);
    cfgKind = k; cfgVictim = v; cfgAggressor = a; cfgValue = val; cfgTrigger = trg;
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic access(input logic we, input logic [3:0] a, input logic d,
                        output logic got, output logic vld);
    @(negedge clk);
    memEn = 1'b1; memWe = we; memAddr = a; memWdata = d;
    @(negedge clk);
    memEn = 1'b0; memWe = 1'b0;
    got = memRdata; vld = memRvalid;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic got, vld;
    logic [2:0] cK; logic [3:0] cV, cA; logic cVal, cTrg;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, "rvalid in reset", memRvalid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "rvalid after reset", memRvalid, 1'b0);
    access(1'b0, 4'd0, 1'b0, got, vld);
    check(1, "cell 0 after reset", got, 1'b0);
    check(2, "rvalid on read", vld, 1'b1);
    @(negedge clk);
    check(2, "rvalid drops", memRvalid, 1'b0);

    cK = 3'd0; cV = '0; cA = '0; cVal = 1'b0; cTrg = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].kind != cK || VEC[i].vic != cV || VEC[i].agg != cA ||
          VEC[i].val != cVal || VEC[i].trg != cTrg) begin
        cK = VEC[i].kind; cV = VEC[i].vic; cA = VEC[i].agg;
        cVal = VEC[i].val; cTrg = VEC[i].trg;
        loadCfg(cK, cV, cA, cVal, cTrg);
      end
      access(VEC[i].we, VEC[i].addr, VEC[i].wd, got, vld);
      if (!VEC[i].we) begin
        check(int'(VEC[i].req), $sformatf("vec %0d rdata", i), got, VEC[i].exp);
        check(int'(VEC[i].req), $sformatf("vec %0d rvalid", i), vld, 1'b1);
      end else begin
        check(2, $sformatf("vec %0d no rvalid on write", i), vld, 1'b0);
      end
    end

    // R3: new inputs without a load do not change the fault
    loadCfg(3'd1, 4'd9, 4'd0, 1'b1, 1'b0);
    @(negedge clk);
    cfgKind = 3'd0; cfgVictim = 4'd0; cfgValue = 1'b0;
    access(1'b0, 4'd9, 1'b0, got, vld);
    check(3, "stuck kept without load", got, 1'b1);

    // R1: reset clears cells and fault settings (cells 5 and 6 hold 1)
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    access(1'b0, 4'd9, 1'b0, got, vld);
    check(1, "fault cleared by reset", got, 1'b0);
    access(1'b0, 4'd5, 1'b0, got, vld);
    check(1, "cell 5 cleared", got, 1'b0);
    access(1'b0, 4'd6, 1'b0, got, vld);
    check(1, "cell 6 cleared", got, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule